// File: doc/BRIEF.md
# Scaled-Index Load/Store Decoder and Address Unit

This block sits in the decode stage of a 64-bit core. It recognises two custom memory instructions that both live under one custom major opcode. Both take their address as a base register plus an index register shifted left by a 2-bit scale. The load form writes one destination register. The store form reads three registers: the base, the index and the data.

The block takes the raw 32-bit instruction word together with the base and index values read from the register file. It reports whether the word is a legal indexed access and, if so, its direction, access size, whether a load result is sign-extended, and the register numbers it names. It also produces the effective address.

The address leaves the block two ways. One is combinational, for the same-cycle memory request. The other is a registered copy for the next pipeline stage; that copy only takes a new value on cycles that carry a legal instruction.

Top module: `sidx_lsu_unit`

## Requirements
- R1: A word with bits [6:0] = 7'b0001011 and bits [14:12] = 3'b110 is an indexed load. For such a load, rd_o = bits [11:7], rs1_o (base) = bits [19:15], rs3_o (index) = bits [31:27], is_store_o = 0 and rs2_o = 0.
- R2: A word with bits [6:0] = 7'b0001011 and bits [14:12] = 3'b111 is an indexed store. For such a store, rs2_o (data) = bits [24:20], rs1_o = bits [19:15], rs3_o = bits [31:27], is_store_o = 1, rd_o = 0 and sign_ext_o = 0.
- R3: The scale sits in bits [26:25] for both forms. addr_o = base_i + (index_i << scale), wrapping modulo 2^64 with no trap.
- R4: When the zero-extend bit is set (bit 24 for a load, bit 11 for a store), only index_i[31:0] is used, zero-extended to 64 bits before the shift.
- R5: The load operation code sits in bits [22:20], and size_o uses 0 = byte, 1 = half, 2 = word, 3 = double. The codes decode as follows:
  - 0: byte, signed
  - 1: half, signed
  - 2: word, signed
  - 3: double, sign_ext_o = 0
  - 4: byte, unsigned
  - 5: half, unsigned
  - 6: word, unsigned
  - 7: illegal

  sign_ext_o = 1 means the loaded value is sign-extended from its size; a signed byte load therefore returns the sign-extension of the byte at addr_o.
- R6: The store operation code sits in bits [9:7]. Codes 0 to 3 give size_o = code. Codes 4 to 7 are illegal.
- R7: The following words give valid_o = 0, with rd_o, rs1_o, rs2_o, rs3_o, size_o, is_store_o and sign_ext_o all 0:
  - any other opcode;
  - any other funct3;
  - load code 7;
  - load bit 23 set;
  - store bit 10 set.
- R8: On each rising clock edge, valid_q_o takes valid_o. addr_q_o takes addr_o when valid_o is 1 and otherwise keeps its value.
- R9: While rst_n is low, valid_q_o = 0 and addr_q_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction word |
| base_i | input | 64 | Base register value |
| index_i | input | 64 | Index register value |
| valid_o | output | 1 | Word is a legal indexed access |
| is_store_o | output | 1 | 1 = store, 0 = load |
| sign_ext_o | output | 1 | Load result is sign-extended |
| size_o | output | 2 | Access size code |
| rd_o | output | 5 | Load destination register |
| rs1_o | output | 5 | Base register number |
| rs2_o | output | 5 | Store data register number |
| rs3_o | output | 5 | Index register number |
| addr_o | output | 64 | Effective address, combinational |
| addr_q_o | output | 64 | Registered effective address |
| valid_q_o | output | 1 | Registered valid |

## Verification
In a single cycle, the registered stage can capture or hold the previous address while the decoder is already presenting a new word and a new combinational address. The bench provokes this in three ways: back-to-back legal instructions, a legal instruction followed by an illegal one, and an illegal one followed by a legal one.

After each edge, it judges two things together. First, addr_q_o must equal the reference address of the last legal word, never the address of the word now on the inputs. Second, addr_o must at the same time show the new word's address.

// File: rtl/sidx_pkg.sv
package sidx_pkg;
  localparam int XLEN       = 64;
  localparam int NARROW_W   = 32;
  localparam int REG_W      = 5;
  localparam int SCALE_W    = 2;
  localparam logic [6:0] OPC_IDX   = 7'b0001011;
  localparam logic [2:0] F3_LOAD   = 3'b110;
  localparam logic [2:0] F3_STORE  = 3'b111;

  typedef enum logic [1:0] {SZ_BYTE, SZ_HALF, SZ_WORD, SZ_DBL} acc_size_e;

  typedef struct packed {
    logic             ok;
    logic             st;
    logic             sgn;
    acc_size_e        size;
    logic             zext;
    logic [SCALE_W-1:0] sc;
    logic [REG_W-1:0] rd;
    logic [REG_W-1:0] rb;
    logic [REG_W-1:0] rx;
    logic [REG_W-1:0] rv;
  } dec_s;

  function automatic logic [XLEN-1:0] widen_index(input logic [XLEN-1:0] idx,
                                                  input logic zext);
    return zext ? {{(XLEN-NARROW_W){1'b0}}, idx[NARROW_W-1:0]} : idx;
  endfunction

  function automatic logic [XLEN-1:0] eff_addr(input logic [XLEN-1:0] base,
                                               input logic [XLEN-1:0] idx,
                                               input logic zext,
                                               input logic [SCALE_W-1:0] sc);
    return base + (widen_index(idx, zext) << sc);
  endfunction
endpackage

// File: rtl/sidx_decode.sv
module sidx_decode
  import sidx_pkg::*;
(
  input  logic [31:0] instr_i,
  output dec_s        dec_o,
  output logic        ld_hit_o,
  output logic        st_hit_o
);
  logic major_ok;
  logic ld_ok;
  logic st_ok;

  always_comb begin
    major_ok = (instr_i[6:0] == OPC_IDX);
    ld_hit_o = major_ok && (instr_i[14:12] == F3_LOAD);
    st_hit_o = major_ok && (instr_i[14:12] == F3_STORE);
    ld_ok    = ld_hit_o && !instr_i[23] && (instr_i[22:20] != 3'd7);
    st_ok    = st_hit_o && !instr_i[10] && !instr_i[9];
  end

  always_comb begin
    dec_o = '0;
    if (ld_ok) begin
      dec_o.ok   = 1'b1;
      dec_o.st   = 1'b0;
      dec_o.size = acc_size_e'(instr_i[21:20]);
      dec_o.sgn  = !instr_i[22] && (instr_i[21:20] != 2'b11);
      dec_o.zext = instr_i[24];
      dec_o.sc   = instr_i[26:25];
      dec_o.rd   = instr_i[11:7];
      dec_o.rb   = instr_i[19:15];
      dec_o.rx   = instr_i[31:27];
    end else if (st_ok) begin
      dec_o.ok   = 1'b1;
      dec_o.st   = 1'b1;
      dec_o.size = acc_size_e'(instr_i[8:7]);
      dec_o.zext = instr_i[11];
      dec_o.sc   = instr_i[26:25];
      dec_o.rv   = instr_i[24:20];
      dec_o.rb   = instr_i[19:15];
      dec_o.rx   = instr_i[31:27];
    end
  end
endmodule

// File: rtl/sidx_agu.sv
module sidx_agu
  import sidx_pkg::*;
(
  input  logic [XLEN-1:0]    base_i,
  input  logic [XLEN-1:0]    index_i,
  input  logic               zext_i,
  input  logic [SCALE_W-1:0] sc_i,
  output logic [XLEN-1:0]    addr_o
);
  always_comb addr_o = eff_addr(base_i, index_i, zext_i, sc_i);
endmodule

// File: rtl/sidx_stage.sv
module sidx_stage #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         en_q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o    <= '0;
      en_q_o <= 1'b0;
    end else begin
      en_q_o <= en_i;
      if (en_i) q_o <= d_i;
    end
  end
endmodule

// File: rtl/sidx_lsu_unit.sv
module sidx_lsu_unit
  import sidx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     instr_i,
  input  logic [63:0]     base_i,
  input  logic [63:0]     index_i,
  output logic            valid_o,
  output logic            is_store_o,
  output logic            sign_ext_o,
  output logic [1:0]      size_o,
  output logic [4:0]      rd_o,
  output logic [4:0]      rs1_o,
  output logic [4:0]      rs2_o,
  output logic [4:0]      rs3_o,
  output logic [63:0]     addr_o,
  output logic [63:0]     addr_q_o,
  output logic            valid_q_o
);
  dec_s        dec;
  logic        ld_hit;
  logic        st_hit;
  logic [63:0] ea;

  sidx_decode u_dec (
    .instr_i  (instr_i),
    .dec_o    (dec),
    .ld_hit_o (ld_hit),
    .st_hit_o (st_hit)
  );

  sidx_agu u_agu (
    .base_i  (base_i),
    .index_i (index_i),
    .zext_i  (dec.zext),
    .sc_i    (dec.sc),
    .addr_o  (ea)
  );

  sidx_stage #(.W(XLEN)) u_stage (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (dec.ok),
    .d_i    (ea),
    .q_o    (addr_q_o),
    .en_q_o (valid_q_o)
  );

  always_comb begin
    valid_o    = dec.ok;
    is_store_o = dec.st;
    sign_ext_o = dec.sgn;
    size_o     = dec.size;
    rd_o       = dec.rd;
    rs1_o      = dec.rb;
    rs2_o      = dec.rv;
    rs3_o      = dec.rx;
    addr_o     = ea;
  end
endmodule

// File: rtl/sidx_lsu_chk.sv
module sidx_lsu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] instr_i,
  input logic [63:0] base_i,
  input logic [63:0] index_i,
  input logic        valid_o,
  input logic        is_store_o,
  input logic        sign_ext_o,
  input logic [4:0]  rd_o,
  input logic [4:0]  rs2_o,
  input logic [63:0] addr_o,
  input logic [63:0] addr_q_o,
  input logic        valid_q_o
);
  logic zx_bit;
  always_comb zx_bit = is_store_o ? instr_i[11] : instr_i[24];

  p_opcode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> instr_i[6:0] == 7'b0001011);

  p_store_no_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && is_store_o) |-> (rd_o == 5'd0 && !sign_ext_o));

  p_plain_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && instr_i[26:25] == 2'b00 && !zx_bit) |-> addr_o == base_i + index_i);

  p_invalid_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (rd_o == 5'd0 && rs2_o == 5'd0 && !is_store_o && !sign_ext_o));

  p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> addr_q_o == $past(addr_o));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |=> $stable(addr_q_o));

  p_valid_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> valid_q_o);

  p_reset_state_r9: assert property (@(posedge clk)
    $rose(rst_n) |-> (!valid_q_o && addr_q_o == 64'd0));
endmodule

bind sidx_lsu_unit sidx_lsu_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .instr_i    (instr_i),
  .base_i     (base_i),
  .index_i    (index_i),
  .valid_o    (valid_o),
  .is_store_o (is_store_o),
  .sign_ext_o (sign_ext_o),
  .rd_o       (rd_o),
  .rs2_o      (rs2_o),
  .addr_o     (addr_o),
  .addr_q_o   (addr_q_o),
  .valid_q_o  (valid_q_o)
);

// File: tb/test_sidx_lsu_unit.sv
module test_sidx_lsu_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr_i = '0;
  logic [63:0] base_i = '0;
  logic [63:0] index_i = '0;
  logic        valid_o, is_store_o, sign_ext_o, valid_q_o;
  logic [1:0]  size_o;
  logic [4:0]  rd_o, rs1_o, rs2_o, rs3_o;
  logic [63:0] addr_o, addr_q_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sidx_lsu_unit i_sidx_lsu_unit (
    .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .base_i(base_i), .index_i(index_i),
    .valid_o(valid_o), .is_store_o(is_store_o), .sign_ext_o(sign_ext_o), .size_o(size_o),
    .rd_o(rd_o), .rs1_o(rs1_o), .rs2_o(rs2_o), .rs3_o(rs3_o),
    .addr_o(addr_o), .addr_q_o(addr_q_o), .valid_q_o(valid_q_o)
  );

  function automatic logic [31:0] mk_ld(input logic [4:0] rd, input logic [4:0] rb,
      input logic [4:0] rx, input logic [1:0] sc, input logic [2:0] op, input logic zx);
    return {rx, sc, zx, 1'b0, op, rb, 3'b110, rd, 7'b0001011};
  endfunction

  function automatic logic [31:0] mk_st(input logic [4:0] rv, input logic [4:0] rb,
      input logic [4:0] rx, input logic [1:0] sc, input logic [2:0] op, input logic zx);
    return {rx, sc, rv, rb, 3'b111, zx, 1'b0, op, 7'b0001011};
  endfunction

  function automatic logic [63:0] ref_ea(input logic [63:0] b, input logic [63:0] x,
      input logic zx, input logic [1:0] sc);
    logic [63:0] v;
    v = zx ? (x & 64'h0000_0000_FFFF_FFFF) : x;
    return b + v * (64'd1 << sc);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] w, input logic [63:0] b, input logic [63:0] x);
    @(negedge clk);
    instr_i = w; base_i = b; index_i = x;
    #1;
  endtask

  task automatic t_reset();
    #1;
    chk("R9 valid_q in reset", {63'd0, valid_q_o}, 64'd0);
    chk("R9 addr_q in reset", addr_q_o, 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_loads();
    logic [63:0] b, x;
    for (int op = 0; op < 7; op++) begin
      b = 64'h1000 + 64'(op) * 64'h40;
      x = 64'h10 + 64'(op);
      drive(mk_ld(5'(op + 3), 5'd9, 5'd17, 2'(op), 3'(op), 1'b0), b, x);
      chk("R1 valid", {63'd0, valid_o}, 64'd1);
      chk("R1 is_store", {63'd0, is_store_o}, 64'd0);
      chk("R1 rd", {59'd0, rd_o}, 64'(op + 3));
      chk("R1 rs1", {59'd0, rs1_o}, 64'd9);
      chk("R1 rs3", {59'd0, rs3_o}, 64'd17);
      chk("R1 rs2 zero", {59'd0, rs2_o}, 64'd0);
      chk("R5 size", {62'd0, size_o}, 64'(op % 4));
      chk("R5 sign", {63'd0, sign_ext_o}, (op < 3) ? 64'd1 : 64'd0);
      chk("R3 load addr", addr_o, ref_ea(b, x, 1'b0, 2'(op)));
    end
  endtask

  task automatic t_stores();
    for (int op = 0; op < 4; op++) begin
      drive(mk_st(5'd21, 5'(op + 1), 5'd30, 2'(3 - op), 3'(op), 1'b0),
            64'hABCD_0000, 64'h0000_0000_0000_0123);
      chk("R2 valid", {63'd0, valid_o}, 64'd1);
      chk("R2 is_store", {63'd0, is_store_o}, 64'd1);
      chk("R2 rs2", {59'd0, rs2_o}, 64'd21);
      chk("R2 rs1", {59'd0, rs1_o}, 64'(op + 1));
      chk("R2 rs3", {59'd0, rs3_o}, 64'd30);
      chk("R2 rd zero", {59'd0, rd_o}, 64'd0);
      chk("R2 no sign", {63'd0, sign_ext_o}, 64'd0);
      chk("R6 size", {62'd0, size_o}, 64'(op));
      chk("R3 store addr", addr_o,
          ref_ea(64'hABCD_0000, 64'h123, 1'b0, 2'(3 - op)));
    end
    for (int op = 4; op < 8; op++) begin
      drive(mk_st(5'd21, 5'd2, 5'd30, 2'd1, 3'(op), 1'b0), 64'h5, 64'h6);
      chk("R6 store code illegal", {63'd0, valid_o}, 64'd0);
    end
  endtask

  task automatic t_zext_wrap();
    logic [63:0] x;
    x = 64'hFFFF_FFFF_8000_0004;
    drive(mk_ld(5'd1, 5'd2, 5'd3, 2'd3, 3'd4, 1'b1), 64'h100, x);
    chk("R4 load zext addr", addr_o, 64'h100 + 64'h4_0000_0020);
    drive(mk_ld(5'd1, 5'd2, 5'd3, 2'd3, 3'd4, 1'b0), 64'h100, x);
    chk("R4 load sext path", addr_o, ref_ea(64'h100, x, 1'b0, 2'd3));
    drive(mk_st(5'd4, 5'd2, 5'd3, 2'd2, 3'd3, 1'b1), 64'h8, x);
    chk("R4 store zext addr", addr_o, 64'h8 + 64'h2_0000_0010);
    drive(mk_ld(5'd1, 5'd2, 5'd3, 2'd1, 3'd3, 1'b0), 64'hFFFF_FFFF_FFFF_FFF0,
          64'h0000_0000_0000_0010);
    chk("R3 wrap", addr_o, 64'h0000_0000_0000_0010);
  endtask

  task automatic t_invalid();
    logic [31:0] w [6];
    w[0] = mk_ld(5'd7, 5'd8, 5'd9, 2'd1, 3'd0, 1'b0) ^ 32'h0000_0040;
    w[1] = {17'h1FFFF, 3'b101, 5'd7, 7'b0001011};
    w[2] = mk_ld(5'd7, 5'd8, 5'd9, 2'd1, 3'd7, 1'b0);
    w[3] = mk_ld(5'd7, 5'd8, 5'd9, 2'd1, 3'd0, 1'b0) | 32'h0080_0000;
    w[4] = mk_st(5'd7, 5'd8, 5'd9, 2'd1, 3'd0, 1'b0) | 32'h0000_0400;
    w[5] = {17'h1FFFF, 3'b000, 5'd7, 7'b0001011};
    foreach (w[i]) begin
      drive(w[i], 64'h77, 64'h88);
      chk("R7 valid low", {63'd0, valid_o}, 64'd0);
      chk("R7 fields zero", {43'd0, rd_o, rs1_o, rs2_o, rs3_o, size_o, is_store_o},
          64'd0);
      chk("R7 sign zero", {63'd0, sign_ext_o}, 64'd0);
    end
  endtask

  task automatic t_pipeline();
    logic [63:0] a1, a2;
    a1 = ref_ea(64'h2000, 64'h3, 1'b0, 2'd2);
    a2 = ref_ea(64'h9000, 64'h5, 1'b0, 2'd1);
    drive(mk_ld(5'd1, 5'd2, 5'd3, 2'd2, 3'd2, 1'b0), 64'h2000, 64'h3);
    @(posedge clk); #1;
    chk("R8 captured", addr_q_o, a1);
    chk("R8 valid_q set", {63'd0, valid_q_o}, 64'd1);
    drive(32'h0000_0013, 64'hDEAD, 64'hBEEF);
    @(posedge clk); #1;
    chk("R8 hold on illegal", addr_q_o, a1);
    chk("R8 valid_q clear", {63'd0, valid_q_o}, 64'd0);
    drive(mk_st(5'd4, 5'd2, 5'd3, 2'd1, 3'd3, 1'b0), 64'h9000, 64'h5);
    chk("R8 old addr still held", addr_q_o, a1);
    chk("R8 new comb addr", addr_o, a2);
    @(posedge clk); #1;
    chk("R8 captured after illegal", addr_q_o, a2);
    drive(mk_ld(5'd1, 5'd2, 5'd3, 2'd0, 3'd0, 1'b0), 64'h40, 64'h2);
    chk("R8 back-to-back held", addr_q_o, a2);
    @(posedge clk); #1;
    chk("R8 back-to-back capture", addr_q_o, 64'h42);
  endtask

  initial begin
    t_reset();
    t_loads();
    t_stores();
    t_zext_wrap();
    t_invalid();
    t_pipeline();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule